// File: doc/BRIEF.md
# Single-Cycle-Per-Tap FIR Filter Engine

This block computes one output of a finite impulse response filter for every input sample it accepts. Coefficients sit in a coefficient bank and past samples in a separate delay-line store. Both are read in the same clock, so one tap is processed per cycle. A sample register feeds the multiplier, the product is held in a product register, and an adder folds that product into a wide accumulator while the next tap is being multiplied.

The delay line is not a separate shift register. Each sample is written one slot further down in the same cycle it is loaded for multiplication. Taps run from the oldest stored sample toward the newest, so the line ends each pass already shifted for the next sample. The host loads coefficients through a simple write port. Input samples arrive through a valid/ready handshake. Each result is presented with a one-cycle valid strobe, rounded and saturated to the sample width. Samples and coefficients are signed Q15.

Top module: `fir_tap_engine`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, out_sample is 0, every coefficient reads as zero and every stored past sample is zero.
- R2: A sample is accepted on a rising edge where in_valid and in_ready are both 1. in_ready is then 0 for exactly DELAY_M+2 cycles and returns to 1 in the cycle in which out_valid is 1.
- R3: out_valid is a single-cycle pulse that rises on the (DELAY_M+2)-th rising edge after the accepting edge. out_sample changes only when out_valid rises and holds its value at all other times.
- R4: The result is y = sum over k = 0..DELAY_M of h[k]*x(n-k). Here x(n) is the sample just accepted, x(n-k) is the sample accepted k acceptances earlier, and h[k] is the coefficient written at coef_addr = k.
- R5: The Q30 sum is converted to Q15 by adding 2^14 and shifting right arithmetically by 15 bits, so exact halves round toward positive infinity.
- R6: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R7: A coefficient write (coef_we = 1) is stored only in a cycle where in_ready is 1. A write in the same cycle as a sample acceptance is used by that sample's pass. A write while in_ready is 0 is ignored.
- R8: A new sample may be accepted in the cycle in which out_valid is 1. Each acceptance moves every stored sample one position older, and the sample DELAY_M+1 acceptances old drops out.
- R9: in_valid asserted while in_ready is 0 has no effect: the offered sample is not stored and does not appear in any later result.
- R10: Partial sums beyond the 32-bit product range do not wrap. The accumulator carries GUARD_W guard bits, so a pass whose running sum exceeds 2^31 but ends in range gives the exact rounded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine idle and able to take a sample |
| in_sample | input | DATA_W | Signed Q15 input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | TAP_AW | Tap index of the coefficient written |
| coef_data | input | COEF_W | Signed Q15 coefficient value |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_sample | output | DATA_W | Rounded, saturated Q15 filter output |

## Verification
Two pairs of events can land in the same cycle. A finished result can be strobed out while the next sample is accepted. A coefficient write can coincide with a sample acceptance. The bench provokes the first by holding in_valid high across a stream of samples, and the second by raising coef_we and in_valid together. A behavioural model with its own queue of past samples and its own pass-length counter predicts in_ready, out_valid and out_sample on every clock. The bench also writes coefficients and offers samples while a pass is running, to show that both are ignored.

// File: rtl/fir_pkg.sv
// Shared definitions for the FIR tap engine.
// Assumes nothing beyond the users importing it.
package fir_pkg;
    // Phases of one filter pass.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/fir_tap_sequencer.sv
// Pass sequencer: accepts a sample when idle, then walks the tap index
// from DELAY_M down to 0, then spends one drain cycle.
// Assumes DELAY_M >= 1.
module fir_tap_sequencer
    import fir_pkg::*;
#(
    parameter int DELAY_M = 7,
    localparam int TAP_AW = $clog2(DELAY_M + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              start,
    output logic              step_move,
    output logic              step_last,
    output logic              step_drain,
    output logic [TAP_AW-1:0] tap_idx
);
    localparam logic [TAP_AW-1:0] OLDEST = TAP_AW'(DELAY_M);

    seq_state_e        state;
    logic [TAP_AW-1:0] cnt;

    // Decode the current phase into datapath strobes.
    always_comb begin
        in_ready   = (state == SEQ_IDLE);
        start      = in_ready && in_valid;
        step_move  = (state == SEQ_RUN) && (cnt != '0);
        step_last  = (state == SEQ_RUN) && (cnt == '0);
        step_drain = (state == SEQ_DRAIN);
        tap_idx    = cnt;
    end

    // Advance the phase and the tap counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state <= SEQ_RUN;
                    cnt   <= OLDEST;
                end
                SEQ_RUN: begin
                    if (cnt == '0) state <= SEQ_DRAIN;
                    else           cnt   <= cnt - 1'b1;
                end
                SEQ_DRAIN: state <= SEQ_IDLE;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fir_delay_line.sv
// Sample store of DELAY_M+1 slots; slot k holds x(n-k).
// A push writes slot 0; a move copies slot dst-1 into slot dst.
// Assumes push and move never coincide and dst >= 1 on a move.
module fir_delay_line #(
    parameter int DATA_W  = 16,
    parameter int DELAY_M = 7,
    localparam int TAP_AW = $clog2(DELAY_M + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              move,
    input  logic [TAP_AW-1:0] move_dst,
    input  logic [TAP_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DELAY_M+1];

    // Asynchronous read port for the sample register.
    assign rd_data = slot[rd_addr];

    // Clear, push the newest sample, or move one sample down a slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= DELAY_M; i++) slot[i] <= '0;
        end else if (push) begin
            slot[0] <= push_data;
        end else if (move) begin
            slot[move_dst] <= slot[move_dst - 1'b1];
        end
    end
endmodule

// File: rtl/fir_coef_bank.sv
// Coefficient store, one register per tap, with one write port and one
// asynchronous read port. Writes to an index above DELAY_M are dropped.
// Assumes the caller gates the write strobe.
module fir_coef_bank #(
    parameter int COEF_W  = 16,
    parameter int DELAY_M = 7,
    localparam int TAP_AW = $clog2(DELAY_M + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [TAP_AW-1:0] waddr,
    input  logic [COEF_W-1:0] wdata,
    input  logic [TAP_AW-1:0] raddr,
    output logic [COEF_W-1:0] rdata
);
    logic [(DELAY_M+1)*COEF_W-1:0] coef_flat;

    for (genvar g = 0; g <= DELAY_M; g++) begin : g_tap
        logic [COEF_W-1:0] q;
        // Hold the coefficient of tap g.
        always_ff @(posedge clk) begin
            if (!rst_n)                           q <= '0;
            else if (we && waddr == TAP_AW'(g))   q <= wdata;
        end
        assign coef_flat[g*COEF_W +: COEF_W] = q;
    end

    // Select the coefficient of the tap being multiplied.
    assign rdata = coef_flat[raddr*COEF_W +: COEF_W];
endmodule

// File: rtl/fir_mac_path.sv
// Sample register -> multiplier -> product register -> adder ->
// accumulator, followed by Q15 rounding and saturation of the final sum.
// Assumes the fractional width of the coefficients is COEF_W-1.
module fir_mac_path #(
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load_t,
    input  logic [DATA_W-1:0] t_in,
    input  logic              mul_en,
    input  logic [COEF_W-1:0] coef,
    input  logic              acc_en,
    input  logic              finish,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + GUARD_W;
    localparam int FRAC_W = COEF_W - 1;
    localparam logic signed [ACC_W-1:0] OUT_MAX =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] OUT_MIN =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] HALF_LSB =
        {{(ACC_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic signed [DATA_W-1:0] t_reg;
    logic signed [PROD_W-1:0] p_reg;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_next;
    logic signed [ACC_W-1:0]  rounded;
    logic signed [ACC_W-1:0]  scaled;
    logic signed [DATA_W-1:0] limited;

    // Multiply, accumulate, round and clamp.
    always_comb begin
        prod     = t_reg * $signed(coef);
        acc_next = acc + {{GUARD_W{p_reg[PROD_W-1]}}, p_reg};
        rounded  = acc_next + HALF_LSB;
        scaled   = rounded >>> FRAC_W;
        if (scaled > OUT_MAX)      limited = OUT_MAX[DATA_W-1:0];
        else if (scaled < OUT_MIN) limited = OUT_MIN[DATA_W-1:0];
        else                       limited = scaled[DATA_W-1:0];
    end

    // Sample register feeding the multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n)      t_reg <= '0;
        else if (load_t) t_reg <= $signed(t_in);
    end

    // Product register and accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            p_reg <= '0;
            acc   <= '0;
        end else begin
            if (mul_en) p_reg <= prod;
            if (acc_en) acc   <= acc_next;
        end
    end

    // Result register and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= finish;
            if (finish) out_sample <= limited;
        end
    end
endmodule

// File: rtl/fir_tap_engine.sv
// FIR engine top: one tap per clock, with the delay-line shift merged
// into the tap loop. Taps run from x(n-DELAY_M) to x(n); DELAY_M+2 busy
// cycles per sample. Assumes DELAY_M >= 1 and Q15 samples/coefficients.
module fir_tap_engine #(
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 16,
    parameter int DELAY_M = 7,
    parameter int GUARD_W = 8,
    localparam int TAP_AW = $clog2(DELAY_M + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              coef_we,
    input  logic [TAP_AW-1:0] coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    localparam logic [TAP_AW-1:0] OLDEST = TAP_AW'(DELAY_M);

    logic              start, step_move, step_last, step_drain;
    logic [TAP_AW-1:0] tap_idx;
    logic [TAP_AW-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [COEF_W-1:0] coef_rd;

    // Sample address: the oldest on acceptance, else the next newer one.
    assign rd_addr = start ? OLDEST : (step_move ? tap_idx - 1'b1 : '0);

    fir_tap_sequencer #(.DELAY_M(DELAY_M)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .start(start), .step_move(step_move), .step_last(step_last),
        .step_drain(step_drain), .tap_idx(tap_idx)
    );

    fir_delay_line #(.DATA_W(DATA_W), .DELAY_M(DELAY_M)) u_line (
        .clk(clk), .rst_n(rst_n), .push(start), .push_data(in_sample),
        .move(step_move), .move_dst(tap_idx), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    fir_coef_bank #(.COEF_W(COEF_W), .DELAY_M(DELAY_M)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(coef_we && in_ready),
        .waddr(coef_addr), .wdata(coef_data), .raddr(tap_idx),
        .rdata(coef_rd)
    );

    fir_mac_path #(.DATA_W(DATA_W), .COEF_W(COEF_W), .GUARD_W(GUARD_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .load_t(start || step_move), .t_in(rd_data),
        .mul_en(step_move || step_last), .coef(coef_rd),
        .acc_en(step_move || step_last || step_drain),
        .finish(step_drain), .out_valid(out_valid), .out_sample(out_sample)
    );
endmodule

// File: rtl/fir_tap_engine_chk.sv
// Protocol checker for fir_tap_engine, attached with bind.
// Counts edges since the last acceptance to time the pass.
module fir_tap_engine_chk #(
    parameter int DATA_W  = 16,
    parameter int DELAY_M = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_sample
);
    localparam int CW = $clog2(DELAY_M + 4);

    logic [CW-1:0] since_acc;

    // Edge count since acceptance: 1 after the accepting edge, 0 when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    since_acc <= '0;
        else if (in_valid && in_ready) since_acc <= CW'(1);
        else if (out_valid)            since_acc <= '0;
        else if (since_acc != '0)      since_acc <= since_acc + 1'b1;
    end

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_busy_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_acc != '0 && !out_valid) |-> !in_ready);

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_acc == CW'(DELAY_M + 3)));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample));

    assert_ready_with_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);
endmodule

bind fir_tap_engine fir_tap_engine_chk #(.DATA_W(DATA_W), .DELAY_M(DELAY_M)) u_fir_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/test_fir_tap_engine.sv
`timescale 1ns/1ps
module test_fir_tap_engine;
    localparam int M    = 7;
    localparam int NTAP = M + 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [15:0] in_sample = '0;
    logic               coef_we = 1'b0;
    logic [2:0]         coef_addr = '0;
    logic signed [15:0] coef_data = '0;
    logic               out_valid;
    logic signed [15:0] out_sample;

    int errors = 0;
    int checks = 0;

    fir_tap_engine #(.DELAY_M(M)) i_fir_tap_engine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .out_valid(out_valid), .out_sample(out_sample)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    longint m_hist[$];
    longint m_coef[NTAP];
    int     m_busy;
    bit     m_ov;
    longint m_out, m_pend;
    bit     m_rdy;

    function automatic longint model_y();
        longint s = 0;
        longint r;
        for (int k = 0; k < NTAP; k++) s += m_hist[k] * m_coef[k];
        r = (s + 16384) >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist = {};
            for (int k = 0; k < NTAP; k++) begin m_hist.push_back(0); m_coef[k] = 0; end
            m_busy = 0; m_ov = 0; m_out = 0; m_pend = 0;
        end else begin
            m_rdy = (m_busy == 0);
            m_ov  = 0;
            if (coef_we && m_rdy) m_coef[coef_addr] = longint'(coef_data);
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin m_ov = 1; m_out = m_pend; end
            end
            if (in_valid && m_rdy) begin
                m_hist.push_front(longint'(in_sample));
                void'(m_hist.pop_back());
                m_pend = model_y();
                m_busy = M + 2;
            end
        end
    end

    // Compare the design against the model on every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 in_ready", longint'(in_ready), longint'(m_busy == 0));
            check("R3 out_valid", longint'(out_valid), longint'(m_ov));
            if (m_ov) check("R4 out_sample", longint'(out_sample), m_out);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; coef_we = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_coef(input int a, input int d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        coef_we = 1'b1; coef_addr = 3'(a); coef_data = 16'(d);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic push(input int s);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_sample = 16'(s);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic get_out(output longint y);
        while (!out_valid) @(negedge clk);
        y = longint'(out_sample);
    endtask

    task automatic push_get(input int s, input longint exp, input string tag);
        longint y;
        push(s);
        get_out(y);
        check(tag, y, exp);
    endtask

    // ---------------- test sequence ----------------
    initial begin
        longint y;
        int sv[3];
        int ev[3];
        int idx;
        int outs;

        do_reset();
        @(negedge clk);
        check("R1 in_ready after reset", longint'(in_ready), 1);
        check("R1 out_valid after reset", longint'(out_valid), 0);
        check("R1 out_sample after reset", longint'(out_sample), 0);
        push_get(1000, 0, "R1 coefficients zero");

        do_reset();
        for (int k = 0; k < NTAP; k++) set_coef(k, 16384);
        push_get(16384, 8192, "R1 history zero");
        push_get(8192, 12288, "R4 two-sample sum");

        // Impulse response walks the taps in index order.
        do_reset();
        for (int k = 0; k < NTAP; k++) set_coef(k, 1000 * (k + 1));
        push_get(32767, 1000, "R4 impulse tap0");
        for (int k = 1; k < NTAP; k++) push_get(0, 1000 * (k + 1), "R4 impulse tap");
        push_get(0, 0, "R8 oldest sample dropped");

        // Rounding of exact and near halves.
        do_reset();
        set_coef(0, 1);
        push_get(16384, 1, "R5 positive half rounds up");
        push_get(-16384, 0, "R5 negative half rounds up");
        push_get(16383, 0, "R5 below half");
        push_get(-16385, -1, "R5 above negative half");

        // Coefficient write with acceptance, then during a pass.
        do_reset();
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16384;
        coef_we = 1'b1; coef_addr = 0; coef_data = 32767;
        @(negedge clk);
        in_valid = 1'b0; coef_we = 1'b0;
        get_out(y);
        check("R7 write with acceptance used", y, 16384);
        push(16384);
        coef_we = 1'b1; coef_addr = 0; coef_data = 0;
        @(negedge clk);
        coef_we = 1'b0;
        get_out(y);
        check("R7 pass result", y, 16384);
        push_get(16384, 16384, "R7 busy write ignored");

        // Samples offered while busy are ignored.
        do_reset();
        set_coef(0, 16384);
        set_coef(1, 16384);
        push(8000);
        in_valid = 1'b1; in_sample = 30000;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        get_out(y);
        check("R9 first result", y, 4000);
        push_get(2000, 5000, "R9 busy sample not stored");

        // Back-to-back stream: acceptance alongside the result strobe.
        sv = '{4000, 6000, -2000};
        ev = '{3000, 5000, 2000};
        idx = 0; outs = 0;
        @(negedge clk);
        while (outs < 3) begin
            if (idx < 3) begin in_valid = 1'b1; in_sample = 16'(sv[idx]); end
            else in_valid = 1'b0;
            if (out_valid) begin
                check("R8 ready with result", longint'(in_ready), 1);
                check("R8 stream result", longint'(out_sample), ev[outs]);
                outs++;
            end
            if (idx < 3 && in_ready) idx++;
            @(negedge clk);
        end
        in_valid = 1'b0;

        // Saturation and guard bits.
        do_reset();
        for (int k = 0; k < NTAP; k++) set_coef(k, 32767);
        push_get(32767, 32766, "R5 full-scale product");
        push_get(32767, 32767, "R6 positive clamp");
        for (int k = 0; k < 6; k++) push_get(32767, 32767, "R6 positive clamp");
        for (int k = 0; k < 7; k++) begin push(-32768); get_out(y); end
        push_get(-32768, -32768, "R6 negative clamp");
        for (int k = 0; k < 4; k++) begin push(32767); get_out(y); end
        for (int k = 0; k < 3; k++) begin push(-32768); get_out(y); end
        push_get(-32768, -4, "R10 guard bits");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule